// File: doc/BRIEF.md
# Bridge Port BAR Region Decoder and Window Translator

This block sits on one port of a two-host bridge and classifies every host access by the BAR it hit and the offset inside that BAR. A few BARs hold several logical regions. BAR0 holds the control words and then the port's own scratchpad, which starts at a programmable offset. BAR1 reaches the other host's scratchpad. BAR2 holds the doorbell slots and then memory window 1, which starts at a programmable offset. BAR3 to BAR5 each hold one more window. For each access the block drives a target code and an address inside that target. A memory-window hit is turned into a 64-bit outbound address. The window's programmed base replaces the BAR base, and the access is refused if it falls past the window's programmed size.

The block also holds this port's scratchpad words. The local host reaches them through BAR0 on port A. The peer host reaches them on port B, which is driven by the other port's BAR1 decode. Both ports can read and write. A window becomes live only when a window-setup strobe gives it a base and a size. The window count is a parameter from 1 to 4. BARs for windows past that count are not decoded.

Top module: `ntb_bar_router`

## Requirements
- R1: After reset no window is active and every scratchpad word reads 0. Both read-data outputs are 0.
- R2: A BAR0 access whose offset is below `spad_off_i` selects the control bank. This is target code 1, `xlat_addr_o` is the offset and there is no error.
- R3: A BAR0 access at or above `spad_off_i` selects the own scratchpad (target code 2). `xlat_addr_o` is the offset minus `spad_off_i`, and the word index is that value shifted right by 2. A read returns the word on `spad_rdata_o` one cycle later, taking the value from before any write in the same cycle. A write stores `req_wdata_i`. In a cycle with no in-range port-A read, `spad_rdata_o` is 0 in the next cycle.
- R4: An own-scratchpad access whose index is at or above SPAD_CNT raises no error. A read returns 0 and a write changes no word.
- R5: Any BAR1 access selects the peer scratchpad (target code 3) with `xlat_addr_o` equal to the offset and no error.
- R6: A BAR2 access with offset below `mw1_off_i` selects the doorbell area (target code 4) with `xlat_addr_o` equal to the offset.
- R7: A BAR2 access at or above `mw1_off_i` uses window 0 with local offset = offset − `mw1_off_i`. BAR3, BAR4 and BAR5 use windows 1, 2 and 3 with local offset = offset. If that window is active and the local offset is below its size, the target is code 5 with no error. `tgt_win_o` then gives the window number and `xlat_addr_o` = window base + local offset.
- R8: An access to a window that is not active, at or past its size, or beyond NUM_MW, and any BAR 6 or 7, raises `err_o`. It also gives target code 0 and `xlat_addr_o` 0, and the write is not forwarded.
- R9: A `mw_cfg_we_i` pulse with `mw_cfg_idx_i` below NUM_MW loads that window's base and size and makes it active, replacing any earlier values. An index at or above NUM_MW changes nothing.
- R10: Port B reads and writes the same scratchpad words by index `pb_idx_i`, with read data on `pb_rdata_o` one cycle later, under the same range and zero rules as R3 and R4.
- R11: When both ports write the same word in the same cycle, the word takes the port-A data.
- R12: `fwd_we_o` is 1 exactly for a valid write with no error. With `req_valid_i` low the target is 0, `err_o` is 0 and `fwd_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host access present this cycle |
| req_bar_i | input | 3 | BAR number hit |
| req_off_i | input | OFF_W | Byte offset inside the BAR |
| req_we_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 32 | Write data for own scratchpad |
| spad_off_i | input | OFF_W | Start of own scratchpad in BAR0 |
| mw1_off_i | input | OFF_W | Start of window 0 in BAR2 |
| mw_cfg_we_i | input | 1 | Window setup strobe |
| mw_cfg_idx_i | input | 2 | Window being set up |
| mw_cfg_addr_i | input | 64 | Window outbound base |
| mw_cfg_size_i | input | OFF_W | Window size in bytes |
| pb_valid_i | input | 1 | Peer scratchpad access |
| pb_we_i | input | 1 | Peer write |
| pb_idx_i | input | IDX_W | Peer word index |
| pb_wdata_i | input | 32 | Peer write data |
| tgt_o | output | 3 | Target code 0 none, 1 control, 2 own pad, 3 peer pad, 4 doorbell, 5 window |
| tgt_win_o | output | 2 | Window number on a window hit |
| xlat_addr_o | output | 64 | Address inside the target |
| err_o | output | 1 | Access refused |
| fwd_we_o | output | 1 | Write forwarded to target |
| spad_rdata_o | output | 32 | Port A scratchpad read data |
| pb_rdata_o | output | 32 | Port B scratchpad read data |

## Verification
The assertions take for granted that `spad_off_i` and `mw1_off_i` hold still while requests arrive. They also take for granted that the decode outputs are sampled only in the cycle their request is valid. The stimulus sets both offsets once, before reset is released. It uses word-aligned offsets and changes window setup only in cycles that a reference model also sees. Range edges are hit exactly: the last in-range word, the first out-of-range index, size − 4 and size itself, and the BAR just past the window count.

// File: rtl/ntb_bar_pkg.sv
`timescale 1ns/1ps
package ntb_bar_pkg;
  typedef enum logic [2:0] {
    TGT_NONE      = 3'd0,
    TGT_CFG       = 3'd1,
    TGT_SPAD_SELF = 3'd2,
    TGT_SPAD_PEER = 3'd3,
    TGT_DBELL     = 3'd4,
    TGT_WIN       = 3'd5
  } tgt_e;
  localparam int unsigned MAX_WIN = 4;
  localparam int unsigned XADDR_W = 64;
endpackage

// File: rtl/ntb_win_regs.sv
`timescale 1ns/1ps
module ntb_win_regs #(
  parameter int unsigned NUM_MW = 3,
  parameter int unsigned OFF_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_idx_i,
  input  logic [63:0]      cfg_addr_i,
  input  logic [OFF_W-1:0] cfg_size_i,
  output logic             win_vld_o  [NUM_MW],
  output logic [63:0]      win_base_o [NUM_MW],
  output logic [OFF_W-1:0] win_size_o [NUM_MW]
);
  for (genvar g = 0; g < NUM_MW; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_vld_o[g]  <= 1'b0;
        win_base_o[g] <= '0;
        win_size_o[g] <= '0;
      end else if (cfg_we_i && cfg_idx_i == 2'(g)) begin
        win_vld_o[g]  <= 1'b1;
        win_base_o[g] <= cfg_addr_i;
        win_size_o[g] <= cfg_size_i;
      end
    end
  end
endmodule

// File: rtl/ntb_bar_decode.sv
`timescale 1ns/1ps
module ntb_bar_decode
  import ntb_bar_pkg::*;
#(
  parameter int unsigned NUM_MW = 3,
  parameter int unsigned OFF_W  = 20
) (
  input  logic             req_valid_i,
  input  logic [2:0]       req_bar_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic             req_we_i,
  input  logic [OFF_W-1:0] spad_off_i,
  input  logic [OFF_W-1:0] mw1_off_i,
  input  logic             win_vld_i  [NUM_MW],
  input  logic [63:0]      win_base_i [NUM_MW],
  input  logic [OFF_W-1:0] win_size_i [NUM_MW],
  output tgt_e             tgt_o,
  output logic [1:0]       win_o,
  output logic [63:0]      xlat_o,
  output logic             err_o,
  output logic             fwd_we_o,
  output logic [OFF_W-1:0] spad_idx_o
);
  logic             use_win;
  logic [2:0]       wsel;
  logic [OFF_W-1:0] loc;
  logic             sel_vld;
  logic [63:0]      sel_base;
  logic [OFF_W-1:0] sel_size;
  logic [OFF_W-1:0] spad_rel;

  assign spad_rel   = req_off_i - spad_off_i;
  assign spad_idx_o = spad_rel >> 2;

  // window selection and local offset inside the window
  always_comb begin
    use_win = 1'b0;
    wsel    = 3'd0;
    loc     = '0;
    case (req_bar_i)
      3'd2: if (req_off_i >= mw1_off_i) begin
        use_win = 1'b1;
        loc     = req_off_i - mw1_off_i;
      end
      3'd3, 3'd4, 3'd5: begin
        use_win = 1'b1;
        wsel    = req_bar_i - 3'd2;
        loc     = req_off_i;
      end
      default: ;
    endcase
  end

  // windows past NUM_MW leave sel_vld low
  always_comb begin
    sel_vld  = 1'b0;
    sel_base = '0;
    sel_size = '0;
    for (int k = 0; k < NUM_MW; k++) begin
      if (wsel == 3'(k)) begin
        sel_vld  = win_vld_i[k];
        sel_base = win_base_i[k];
        sel_size = win_size_i[k];
      end
    end
  end

  always_comb begin
    tgt_o  = TGT_NONE;
    xlat_o = '0;
    err_o  = 1'b0;
    if (req_valid_i) begin
      case (req_bar_i)
        3'd0: if (req_off_i < spad_off_i) begin
          tgt_o  = TGT_CFG;
          xlat_o = 64'(req_off_i);
        end else begin
          tgt_o  = TGT_SPAD_SELF;
          xlat_o = 64'(spad_rel);
        end
        3'd1: begin
          tgt_o  = TGT_SPAD_PEER;
          xlat_o = 64'(req_off_i);
        end
        3'd2, 3'd3, 3'd4, 3'd5: begin
          if (!use_win) begin
            tgt_o  = TGT_DBELL;
            xlat_o = 64'(req_off_i);
          end else if (sel_vld && loc < sel_size) begin
            tgt_o  = TGT_WIN;
            xlat_o = sel_base + 64'(loc);
          end else begin
            err_o  = 1'b1;
          end
        end
        default: err_o = 1'b1;
      endcase
    end
  end

  assign win_o    = wsel[1:0];
  assign fwd_we_o = req_valid_i & req_we_i & ~err_o;
endmodule

// File: rtl/ntb_spad_ram.sv
`timescale 1ns/1ps
module ntb_spad_ram #(
  parameter int unsigned SPAD_CNT = 12,
  parameter int unsigned IW       = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_rd_i,
  input  logic          a_we_i,
  input  logic [IW-1:0] a_idx_i,
  input  logic [31:0]   a_wdata_i,
  input  logic          b_rd_i,
  input  logic          b_we_i,
  input  logic [IW-1:0] b_idx_i,
  input  logic [31:0]   b_wdata_i,
  output logic [31:0]   a_rdata_o,
  output logic [31:0]   b_rdata_o
);
  localparam int unsigned AW = (SPAD_CNT > 1) ? $clog2(SPAD_CNT) : 1;
  localparam logic [IW-1:0] CNT_L = IW'(SPAD_CNT);

  logic [31:0] mem [SPAD_CNT];
  logic        a_ok, b_ok;

  assign a_ok = a_idx_i < CNT_L;
  assign b_ok = b_idx_i < CNT_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SPAD_CNT; i++) mem[i] <= '0;
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      a_rdata_o <= (a_rd_i && a_ok) ? mem[a_idx_i[AW-1:0]] : '0;
      b_rdata_o <= (b_rd_i && b_ok) ? mem[b_idx_i[AW-1:0]] : '0;
      // port A is written last so it wins a same-word collision
      if (b_we_i && b_ok) mem[b_idx_i[AW-1:0]] <= b_wdata_i;
      if (a_we_i && a_ok) mem[a_idx_i[AW-1:0]] <= a_wdata_i;
    end
  end
endmodule

// File: rtl/ntb_bar_router.sv
`timescale 1ns/1ps
module ntb_bar_router
  import ntb_bar_pkg::*;
#(
  parameter int unsigned NUM_MW   = 3,
  parameter int unsigned OFF_W    = 20,
  parameter int unsigned SPAD_CNT = 12,
  parameter int unsigned IDX_W    = $clog2(SPAD_CNT) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_bar_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic             req_we_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [OFF_W-1:0] spad_off_i,
  input  logic [OFF_W-1:0] mw1_off_i,
  input  logic             mw_cfg_we_i,
  input  logic [1:0]       mw_cfg_idx_i,
  input  logic [63:0]      mw_cfg_addr_i,
  input  logic [OFF_W-1:0] mw_cfg_size_i,
  input  logic             pb_valid_i,
  input  logic             pb_we_i,
  input  logic [IDX_W-1:0] pb_idx_i,
  input  logic [31:0]      pb_wdata_i,
  output logic [2:0]       tgt_o,
  output logic [1:0]       tgt_win_o,
  output logic [63:0]      xlat_addr_o,
  output logic             err_o,
  output logic             fwd_we_o,
  output logic [31:0]      spad_rdata_o,
  output logic [31:0]      pb_rdata_o
);
  logic             win_vld  [NUM_MW];
  logic [63:0]      win_base [NUM_MW];
  logic [OFF_W-1:0] win_size [NUM_MW];
  tgt_e             tgt;
  logic [OFF_W-1:0] spad_idx;
  logic             self_hit;

  ntb_win_regs #(.NUM_MW(NUM_MW), .OFF_W(OFF_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (mw_cfg_we_i),
    .cfg_idx_i  (mw_cfg_idx_i),
    .cfg_addr_i (mw_cfg_addr_i),
    .cfg_size_i (mw_cfg_size_i),
    .win_vld_o  (win_vld),
    .win_base_o (win_base),
    .win_size_o (win_size)
  );

  ntb_bar_decode #(.NUM_MW(NUM_MW), .OFF_W(OFF_W)) u_dec (
    .req_valid_i (req_valid_i),
    .req_bar_i   (req_bar_i),
    .req_off_i   (req_off_i),
    .req_we_i    (req_we_i),
    .spad_off_i  (spad_off_i),
    .mw1_off_i   (mw1_off_i),
    .win_vld_i   (win_vld),
    .win_base_i  (win_base),
    .win_size_i  (win_size),
    .tgt_o       (tgt),
    .win_o       (tgt_win_o),
    .xlat_o      (xlat_addr_o),
    .err_o       (err_o),
    .fwd_we_o    (fwd_we_o),
    .spad_idx_o  (spad_idx)
  );

  assign tgt_o    = tgt;
  assign self_hit = (tgt == TGT_SPAD_SELF);

  ntb_spad_ram #(.SPAD_CNT(SPAD_CNT), .IW(OFF_W)) u_spad (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_rd_i    (self_hit & ~req_we_i),
    .a_we_i    (self_hit & req_we_i),
    .a_idx_i   (spad_idx),
    .a_wdata_i (req_wdata_i),
    .b_rd_i    (pb_valid_i & ~pb_we_i),
    .b_we_i    (pb_valid_i & pb_we_i),
    .b_idx_i   ({{(OFF_W-IDX_W){1'b0}}, pb_idx_i}),
    .b_wdata_i (pb_wdata_i),
    .a_rdata_o (spad_rdata_o),
    .b_rdata_o (pb_rdata_o)
  );
endmodule

// File: rtl/ntb_bar_router_chk.sv
`timescale 1ns/1ps
module ntb_bar_router_chk #(
  parameter int unsigned NUM_MW   = 3,
  parameter int unsigned OFF_W    = 20,
  parameter int unsigned SPAD_CNT = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [2:0]       req_bar_i,
  input logic [OFF_W-1:0] req_off_i,
  input logic             req_we_i,
  input logic [OFF_W-1:0] spad_off_i,
  input logic [2:0]       tgt_o,
  input logic [1:0]       tgt_win_o,
  input logic [63:0]      xlat_addr_o,
  input logic             err_o,
  input logic             fwd_we_o,
  input logic [31:0]      spad_rdata_o
);
  localparam logic [OFF_W-1:0] CNT_L = OFF_W'(SPAD_CNT);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (tgt_o == 3'd0 && !err_o && !fwd_we_o));

  assert_err_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!fwd_we_o && tgt_o == 3'd0 && xlat_addr_o == 64'd0));

  assert_undecoded_bar_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && 32'(req_bar_i) >= 32'(2 + NUM_MW)) |-> err_o);

  assert_win_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == 3'd5) |-> (32'(tgt_win_o) < 32'(NUM_MW) && !err_o));

  assert_peer_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_bar_i == 3'd1) |-> (tgt_o == 3'd3 && xlat_addr_o == 64'(req_off_i)));

  assert_spad_oob_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_bar_i == 3'd0 && !req_we_i && req_off_i >= spad_off_i &&
     ((req_off_i - spad_off_i) >> 2) >= CNT_L) |=> (spad_rdata_o == 32'd0));
endmodule

bind ntb_bar_router ntb_bar_router_chk #(
  .NUM_MW(NUM_MW), .OFF_W(OFF_W), .SPAD_CNT(SPAD_CNT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_bar_i    (req_bar_i),
  .req_off_i    (req_off_i),
  .req_we_i     (req_we_i),
  .spad_off_i   (spad_off_i),
  .tgt_o        (tgt_o),
  .tgt_win_o    (tgt_win_o),
  .xlat_addr_o  (xlat_addr_o),
  .err_o        (err_o),
  .fwd_we_o     (fwd_we_o),
  .spad_rdata_o (spad_rdata_o)
);

// File: tb/sim_ntb_bar_router.sv
`timescale 1ns/1ps
module sim_ntb_bar_router;
  localparam int NMW   = 3;
  localparam int OW    = 20;
  localparam int CNT   = 12;
  localparam int IW    = $clog2(CNT) + 1;
  localparam logic [OW-1:0] SOFF = 20'h40;
  localparam logic [OW-1:0] MOFF = 20'h100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 0; logic [2:0] req_bar_i = 0; logic [OW-1:0] req_off_i = 0;
  logic req_we_i = 0; logic [31:0] req_wdata_i = 0;
  logic mw_cfg_we_i = 0; logic [1:0] mw_cfg_idx_i = 0; logic [63:0] mw_cfg_addr_i = 0;
  logic [OW-1:0] mw_cfg_size_i = 0;
  logic pb_valid_i = 0; logic pb_we_i = 0; logic [IW-1:0] pb_idx_i = 0; logic [31:0] pb_wdata_i = 0;
  logic [2:0] tgt_o; logic [1:0] tgt_win_o; logic [63:0] xlat_addr_o;
  logic err_o, fwd_we_o; logic [31:0] spad_rdata_o, pb_rdata_o;

  int checks = 0;
  int errors = 0;

  logic [63:0]   m_base [4];
  logic [OW-1:0] m_size [4];
  bit            m_vld  [4];
  logic [31:0]   m_spad [CNT];
  logic [31:0]   exp_ra, exp_rb;

  always #2.5 clk = ~clk;

  ntb_bar_router #(.NUM_MW(NMW), .OFF_W(OW), .SPAD_CNT(CNT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_bar_i(req_bar_i), .req_off_i(req_off_i),
    .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .spad_off_i(SOFF), .mw1_off_i(MOFF),
    .mw_cfg_we_i(mw_cfg_we_i), .mw_cfg_idx_i(mw_cfg_idx_i),
    .mw_cfg_addr_i(mw_cfg_addr_i), .mw_cfg_size_i(mw_cfg_size_i),
    .pb_valid_i(pb_valid_i), .pb_we_i(pb_we_i), .pb_idx_i(pb_idx_i), .pb_wdata_i(pb_wdata_i),
    .tgt_o(tgt_o), .tgt_win_o(tgt_win_o), .xlat_addr_o(xlat_addr_o),
    .err_o(err_o), .fwd_we_o(fwd_we_o),
    .spad_rdata_o(spad_rdata_o), .pb_rdata_o(pb_rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: check decode, advance model, check read data
  task automatic tick(input string tag);
    int e_tgt, w, idx;
    logic [63:0] e_x;
    logic [OW-1:0] loc;
    bit e_err, win;
    #1;
    e_tgt = 0; e_x = 0; e_err = 0; win = 0; w = 0; loc = 0;
    if (req_valid_i) begin
      if (req_bar_i == 0) begin
        if (req_off_i < SOFF) begin e_tgt = 1; e_x = 64'(req_off_i); end
        else begin e_tgt = 2; e_x = 64'(req_off_i - SOFF); end
      end else if (req_bar_i == 1) begin e_tgt = 3; e_x = 64'(req_off_i); end
      else if (req_bar_i == 2 && req_off_i < MOFF) begin e_tgt = 4; e_x = 64'(req_off_i); end
      else if (req_bar_i == 2) begin win = 1; w = 0; loc = req_off_i - MOFF; end
      else if (req_bar_i <= 5) begin win = 1; w = int'(req_bar_i) - 2; loc = req_off_i; end
      else e_err = 1;
      if (win) begin
        if (w < NMW && m_vld[w] && loc < m_size[w]) begin e_tgt = 5; e_x = m_base[w] + 64'(loc); end
        else e_err = 1;
      end
    end
    chk(tgt_o == 3'(e_tgt), tag, "tgt", 64'(tgt_o), 64'(e_tgt));
    chk(err_o == e_err, tag, "err", 64'(err_o), 64'(e_err));
    chk(xlat_addr_o == e_x, tag, "xlat", xlat_addr_o, e_x);
    chk(fwd_we_o == (req_valid_i && req_we_i && !e_err), tag, "fwd_we",
        64'(fwd_we_o), 64'(req_valid_i && req_we_i && !e_err));
    if (e_tgt == 5) chk(tgt_win_o == 2'(w), tag, "win", 64'(tgt_win_o), 64'(w));
    // reads see the words before this cycle's writes
    idx = int'((req_off_i - SOFF) >> 2);
    exp_ra = (e_tgt == 2 && !req_we_i && idx < CNT) ? m_spad[idx] : 32'd0;
    exp_rb = (pb_valid_i && !pb_we_i && int'(pb_idx_i) < CNT) ? m_spad[int'(pb_idx_i)] : 32'd0;
    if (pb_valid_i && pb_we_i && int'(pb_idx_i) < CNT) m_spad[int'(pb_idx_i)] = pb_wdata_i;
    if (e_tgt == 2 && req_we_i && idx < CNT) m_spad[idx] = req_wdata_i;
    if (mw_cfg_we_i && int'(mw_cfg_idx_i) < NMW) begin
      m_vld[mw_cfg_idx_i] = 1; m_base[mw_cfg_idx_i] = mw_cfg_addr_i; m_size[mw_cfg_idx_i] = mw_cfg_size_i;
    end
    @(negedge clk);
    chk(spad_rdata_o == exp_ra, tag, "spad_rdata", 64'(spad_rdata_o), 64'(exp_ra));
    chk(pb_rdata_o == exp_rb, tag, "pb_rdata", 64'(pb_rdata_o), 64'(exp_rb));
    req_valid_i = 0; req_we_i = 0; mw_cfg_we_i = 0; pb_valid_i = 0; pb_we_i = 0;
  endtask

  task automatic acc(input logic [2:0] bar, input logic [OW-1:0] off, input bit we, input logic [31:0] wd);
    req_valid_i = 1; req_bar_i = bar; req_off_i = off; req_we_i = we; req_wdata_i = wd;
  endtask

  task automatic pacc(input logic [IW-1:0] idx, input bit we, input logic [31:0] wd);
    pb_valid_i = 1; pb_idx_i = idx; pb_we_i = we; pb_wdata_i = wd;
  endtask

  task automatic wcfg(input logic [1:0] idx, input logic [63:0] a, input logic [OW-1:0] s);
    mw_cfg_we_i = 1; mw_cfg_idx_i = idx; mw_cfg_addr_i = a; mw_cfg_size_i = s;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_base[i] = 0; m_size[i] = 0; end
    for (int i = 0; i < CNT; i++) m_spad[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk(spad_rdata_o == 0 && pb_rdata_o == 0, "R1", "reset rdata", 64'(spad_rdata_o), 0);
    // R1: nothing active after reset
    acc(3'd3, 20'h0, 0, 0); tick("R1");
    acc(3'd2, MOFF, 0, 0); tick("R1");
    acc(3'd0, SOFF, 0, 0); tick("R1");
    // R12 idle
    req_bar_i = 3'd7; req_off_i = 20'hFFFFF; tick("R12");
    // R2 control bank
    acc(3'd0, 20'h10, 1, 32'h11); tick("R2");
    acc(3'd0, SOFF - 4, 0, 0); tick("R2");
    // R3 own pad
    acc(3'd0, SOFF + 8, 1, 32'hCAFE0002); tick("R3");
    acc(3'd0, SOFF + 8, 0, 0); tick("R3");
    acc(3'd0, SOFF + 44, 1, 32'hBEEF000B); tick("R3");
    acc(3'd0, SOFF + 44, 0, 0); tick("R3");
    // R4 index past count
    acc(3'd0, SOFF + 48, 1, 32'hDEAD); tick("R4");
    acc(3'd0, SOFF + 48, 0, 0); tick("R4");
    acc(3'd0, SOFF + 60, 0, 0); tick("R4");
    acc(3'd0, SOFF, 0, 0); tick("R4");
    // R5 peer pad
    acc(3'd1, 20'h24, 1, 32'h5); tick("R5");
    acc(3'd1, 20'h3C, 0, 0); tick("R5");
    // R6 doorbells
    acc(3'd2, 20'h80, 1, 32'h1); tick("R6");
    acc(3'd2, MOFF - 4, 0, 0); tick("R6");
    // R9 window setup
    wcfg(2'd0, 64'h0000_0001_0000_0000, 20'h1000); tick("R9");
    wcfg(2'd1, 64'h0000_0002_0000_0800, 20'h200); tick("R9");
    wcfg(2'd3, 64'h0000_0003_0000_0000, 20'h1000); tick("R9");
    acc(3'd5, 20'h0, 0, 0); tick("R9");
    // R7 hits
    acc(3'd2, MOFF + 20'h10, 1, 0); tick("R7");
    acc(3'd2, MOFF + 20'hFFC, 0, 0); tick("R7");
    acc(3'd3, 20'h1FC, 1, 0); tick("R7");
    // R8 misses
    acc(3'd2, MOFF + 20'h1000, 1, 0); tick("R8");
    acc(3'd3, 20'h200, 1, 0); tick("R8");
    acc(3'd4, 20'h0, 1, 0); tick("R8");
    acc(3'd6, 20'h0, 1, 0); tick("R8");
    acc(3'd7, 20'h4, 0, 0); tick("R8");
    wcfg(2'd2, 64'hFFFF_FFFF_FFFF_F000, 20'h800); tick("R9");
    acc(3'd4, 20'h7FC, 0, 0); tick("R7");
    wcfg(2'd1, 64'h0000_0004_0000_0000, 20'h100); tick("R9");
    acc(3'd3, 20'h100, 0, 0); tick("R8");
    acc(3'd3, 20'hFC, 1, 0); tick("R7");
    // R10 peer port
    pacc(5'd5, 1, 32'hA5A5_0005); tick("R10");
    pacc(5'd5, 0, 0); acc(3'd0, SOFF + 20, 0, 0); tick("R10");
    pacc(5'd12, 1, 32'h1234); tick("R10");
    pacc(5'd12, 0, 0); tick("R10");
    pacc(5'd2, 0, 0); tick("R10");
    // R11 collision and read-before-write
    pacc(5'd7, 1, 32'hBBBB_0007); acc(3'd0, SOFF + 28, 1, 32'hAAAA_0007); tick("R11");
    pacc(5'd7, 0, 0); acc(3'd0, SOFF + 28, 0, 0); tick("R11");
    pacc(5'd7, 1, 32'h7777); acc(3'd0, SOFF + 28, 0, 0); tick("R3");
    pacc(5'd7, 0, 0); tick("R10");
    acc(3'd0, SOFF + 36, 1, 32'h9); pacc(5'd9, 0, 0); tick("R10");
    pacc(5'd9, 0, 0); tick("R10");
    tick("R12");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule